// File: doc/BRIEF.md
# Dual-Clock Inter-Processor Mailbox

This block lets two processors, side A and side B, exchange words and wake each other up when they run on unrelated bus clocks. Each side has its own small register window. A word written into a side's outgoing slot shows up in the matching incoming slot of the other side. Every handoff crosses between the two clock domains through a toggle request/acknowledge pair with two-flop synchronizers.

Each direction has four data slots of 32 bits. A data slot raises a receive-full interrupt at the reader and gives the writer an acknowledge: its transmit-empty flag comes back once the reader has taken the word. Each direction also has four doorbells. A doorbell carries no data and no acknowledge. It only sets a pending flag on the far side, and software clears that flag by writing one to it. Each side has a single active-high level interrupt. It is the OR of all pending sources whose enable bit is set.

Side register window (word address on `*_addr_i`): 0..3 are the outgoing data slots 0..3 (write only), 4..7 are the incoming data slots 0..3 (read), 8 is status, 9 is the interrupt enable, 10 rings doorbells (bit i rings doorbell i), and 11 holds the doorbell pending flags (read returns them in bits 3:0, and writing 1 to bit i clears flag i). Status and enable share one layout: bits 3:0 are transmit-empty per slot, bits 7:4 are receive-full per slot, and bits 11:8 are doorbell pending. Reads are combinational from the address. Unused addresses and bits read as zero.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, both sides read status 0x00F (every outgoing slot empty, nothing full or pending), read enable 0, and hold their interrupt low.
- R2: A word written to outgoing slot i on one side sets receive-full bit (4+i) on the other side within three of that side's clock edges, and reading incoming slot i there (address 4+i) returns the word, in both directions.
- R3: Reading an incoming slot that is full clears its receive-full bit at the next reader clock edge. The sender's transmit-empty bit i sets again within four sender clock edges after that.
- R4: A write to an outgoing slot whose transmit-empty bit is clear is ignored, and the word already in flight is the one the receiver reads.
- R5: Transmit-empty bit i stays clear for as long as the far side has not read the word.
- R6: Writing 1 to bit i of address 10 sets doorbell pending bit i on the far side within four far-side clock edges. The bit is visible in status bits 11:8 and in address 11 bits 3:0.
- R7: Writing to address 11 clears exactly the pending bits written as 1. Bits written as 0 keep their state.
- R8: A doorbell arriving in the same receiver cycle as a clear of that same bit leaves the bit set.
- R9: Each side's interrupt is high exactly when some status bit and its enable bit (same position at address 9) are both set. This includes the transmit-empty acknowledge after the far side reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Side A clock |
| clk_b_i | input | 1 | Side B clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| a_we_i | input | 1 | Side A write strobe |
| a_re_i | input | 1 | Side A read strobe (needed for read side effects) |
| a_addr_i | input | 4 | Side A word address |
| a_wdata_i | input | 32 | Side A write data |
| a_rdata_o | output | 32 | Side A read data |
| a_irq_o | output | 1 | Side A level interrupt |
| b_we_i | input | 1 | Side B write strobe |
| b_re_i | input | 1 | Side B read strobe |
| b_addr_i | input | 4 | Side B word address |
| b_wdata_i | input | 32 | Side B write data |
| b_rdata_o | output | 32 | Side B read data |
| b_irq_o | output | 1 | Side B level interrupt |

## Verification
Several properties are checked on every clock edge:
- a transmit-empty flag drops only after a write to that slot;
- a slot's outgoing word stays stable while the slot is not empty;
- a receive-full flag drops only after a read;
- a doorbell pending flag drops only after a clear of that bit, and an arriving ring always leaves its flag set;
- an interrupt stays low while its enables are all zero.

Only the bench's scenarios can show the rest: the end-to-end data values, the crossing latency, the acknowledge round trip, the ignored second write, and the exact edge alignment of a ring meeting a clear.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int CH_N      = 4;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 4;
  localparam int SRC_W     = 3 * CH_N;
  localparam int ADDR_TX0  = 0;
  localparam int ADDR_RX0  = ADDR_TX0 + CH_N;
  localparam int ADDR_STAT = ADDR_RX0 + CH_N;
  localparam int ADDR_IEN  = ADDR_STAT + 1;
  localparam int ADDR_RING = ADDR_IEN + 1;
  localparam int ADDR_BELL = ADDR_RING + 1;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/mbox_data_link.sv
module mbox_data_link import mbox_pkg::*; (
  input  logic              clk_s_i,
  input  logic              clk_r_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic              empty_o,
  output logic              full_o,
  output logic [DATA_W-1:0] word_o
);
  logic req_q, ack_q, req_r, ack_s;
  logic [DATA_W-1:0] data_q;

  mbox_sync #(.W(1)) u_req_sync (.clk_i(clk_r_i), .rst_ni(rst_ni), .d_i(req_q), .q_o(req_r));
  mbox_sync #(.W(1)) u_ack_sync (.clk_i(clk_s_i), .rst_ni(rst_ni), .d_i(ack_q), .q_o(ack_s));

  assign empty_o = (req_q == ack_s);
  assign full_o  = (req_r != ack_q);
  // data_q is held until the acknowledge returns, so the reader samples it directly
  assign word_o  = data_q;

  always_ff @(posedge clk_s_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      data_q <= '0;
    end else if (wr_i && empty_o) begin
      req_q  <= ~req_q;
      data_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_r_i or negedge rst_ni) begin
    if (!rst_ni)            ack_q <= 1'b0;
    else if (rd_i && full_o) ack_q <= ~ack_q;
  end
endmodule

// File: rtl/mbox_bell_link.sv
module mbox_bell_link (
  input  logic clk_s_i,
  input  logic clk_r_i,
  input  logic rst_ni,
  input  logic ring_i,
  output logic hit_o
);
  logic tgl_q, tgl_r, last_q;

  always_ff @(posedge clk_s_i or negedge rst_ni) begin
    if (!rst_ni)     tgl_q <= 1'b0;
    else if (ring_i) tgl_q <= ~tgl_q;
  end

  mbox_sync #(.W(1)) u_sync (.clk_i(clk_r_i), .rst_ni(rst_ni), .d_i(tgl_q), .q_o(tgl_r));

  always_ff @(posedge clk_r_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= tgl_r;
  end
  assign hit_o = tgl_r ^ last_q;
endmodule

// File: rtl/mbox_port.sv
module mbox_port import mbox_pkg::*; (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic                        re_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic                        irq_o,
  input  logic [CH_N-1:0]             tx_empty_i,
  input  logic [CH_N-1:0]             rx_full_i,
  input  logic [CH_N-1:0][DATA_W-1:0] rx_word_i,
  input  logic [CH_N-1:0]             bell_hit_i,
  output logic [CH_N-1:0]             tx_wr_o,
  output logic [DATA_W-1:0]           tx_wdata_o,
  output logic [CH_N-1:0]             rx_rd_o,
  output logic [CH_N-1:0]             ring_o,
  output logic [SRC_W-1:0]            ien_o,
  output logic [CH_N-1:0]             pend_o
);
  logic [SRC_W-1:0] ien_q, stat;
  logic [CH_N-1:0]  pend_q, clr;

  for (genvar i = 0; i < CH_N; i++) begin : g_strobe
    assign tx_wr_o[i] = we_i && (addr_i == ADDR_W'(ADDR_TX0 + i));
    assign rx_rd_o[i] = re_i && (addr_i == ADDR_W'(ADDR_RX0 + i));
  end

  assign tx_wdata_o = wdata_i;
  assign ring_o     = (we_i && addr_i == ADDR_W'(ADDR_RING)) ? wdata_i[CH_N-1:0] : '0;
  assign clr        = (we_i && addr_i == ADDR_W'(ADDR_BELL)) ? wdata_i[CH_N-1:0] : '0;
  assign stat       = {pend_q, rx_full_i, tx_empty_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= '0;
      pend_q <= '0;
    end else begin
      if (we_i && addr_i == ADDR_W'(ADDR_IEN)) ien_q <= wdata_i[SRC_W-1:0];
      pend_q <= (pend_q & ~clr) | bell_hit_i; // arrival wins over clear
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < CH_N; i++)
      if (addr_i == ADDR_W'(ADDR_RX0 + i)) rdata_o = rx_word_i[i];
    if (addr_i == ADDR_W'(ADDR_STAT)) rdata_o = DATA_W'(stat);
    if (addr_i == ADDR_W'(ADDR_IEN))  rdata_o = DATA_W'(ien_q);
    if (addr_i == ADDR_W'(ADDR_BELL)) rdata_o = DATA_W'(pend_q);
  end

  assign irq_o  = |(stat & ien_q);
  assign ien_o  = ien_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox import mbox_pkg::*; (
  input  logic              clk_a_i,
  input  logic              clk_b_i,
  input  logic              rst_ni,
  input  logic              a_we_i,
  input  logic              a_re_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  output logic              a_irq_o,
  input  logic              b_we_i,
  input  logic              b_re_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o,
  output logic              b_irq_o
);
  logic [CH_N-1:0]             a_tx_wr, b_tx_wr, a_rx_rd, b_rx_rd;
  logic [DATA_W-1:0]           a_tx_wdata, b_tx_wdata;
  logic [CH_N-1:0]             ab_empty, ab_full, ba_empty, ba_full;
  logic [CH_N-1:0][DATA_W-1:0] ab_word, ba_word;
  logic [CH_N-1:0]             a_ring, b_ring, a_hit, b_hit;
  logic [SRC_W-1:0]            a_ien, b_ien;
  logic [CH_N-1:0]             a_pend, b_pend;

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    mbox_data_link u_ab (
      .clk_s_i(clk_a_i), .clk_r_i(clk_b_i), .rst_ni(rst_ni),
      .wr_i(a_tx_wr[i]), .wdata_i(a_tx_wdata), .rd_i(b_rx_rd[i]),
      .empty_o(ab_empty[i]), .full_o(ab_full[i]), .word_o(ab_word[i]));
    mbox_data_link u_ba (
      .clk_s_i(clk_b_i), .clk_r_i(clk_a_i), .rst_ni(rst_ni),
      .wr_i(b_tx_wr[i]), .wdata_i(b_tx_wdata), .rd_i(a_rx_rd[i]),
      .empty_o(ba_empty[i]), .full_o(ba_full[i]), .word_o(ba_word[i]));
    mbox_bell_link u_bell_ab (
      .clk_s_i(clk_a_i), .clk_r_i(clk_b_i), .rst_ni(rst_ni),
      .ring_i(a_ring[i]), .hit_o(b_hit[i]));
    mbox_bell_link u_bell_ba (
      .clk_s_i(clk_b_i), .clk_r_i(clk_a_i), .rst_ni(rst_ni),
      .ring_i(b_ring[i]), .hit_o(a_hit[i]));
  end

  mbox_port u_port_a (
    .clk_i(clk_a_i), .rst_ni(rst_ni), .we_i(a_we_i), .re_i(a_re_i),
    .addr_i(a_addr_i), .wdata_i(a_wdata_i), .rdata_o(a_rdata_o), .irq_o(a_irq_o),
    .tx_empty_i(ab_empty), .rx_full_i(ba_full), .rx_word_i(ba_word), .bell_hit_i(a_hit),
    .tx_wr_o(a_tx_wr), .tx_wdata_o(a_tx_wdata), .rx_rd_o(a_rx_rd), .ring_o(a_ring),
    .ien_o(a_ien), .pend_o(a_pend));

  mbox_port u_port_b (
    .clk_i(clk_b_i), .rst_ni(rst_ni), .we_i(b_we_i), .re_i(b_re_i),
    .addr_i(b_addr_i), .wdata_i(b_wdata_i), .rdata_o(b_rdata_o), .irq_o(b_irq_o),
    .tx_empty_i(ba_empty), .rx_full_i(ab_full), .rx_word_i(ab_word), .bell_hit_i(b_hit),
    .tx_wr_o(b_tx_wr), .tx_wdata_o(b_tx_wdata), .rx_rd_o(b_rx_rd), .ring_o(b_ring),
    .ien_o(b_ien), .pend_o(b_pend));
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk import mbox_pkg::*; (
  input logic                        clk_a_i,
  input logic                        clk_b_i,
  input logic                        rst_ni,
  input logic                        a_irq_o,
  input logic                        b_irq_o,
  input logic [SRC_W-1:0]            a_ien,
  input logic [SRC_W-1:0]            b_ien,
  input logic [CH_N-1:0]             ab_empty,
  input logic [CH_N-1:0]             a_tx_wr,
  input logic [CH_N-1:0][DATA_W-1:0] ab_word,
  input logic [CH_N-1:0]             ab_full,
  input logic [CH_N-1:0]             b_rx_rd,
  input logic [CH_N-1:0]             b_pend,
  input logic [CH_N-1:0]             b_hit,
  input logic                        b_we_i,
  input logic [ADDR_W-1:0]           b_addr_i,
  input logic [CH_N-1:0]             b_wlow
);
  logic [CH_N-1:0] b_clr;
  assign b_clr = (b_we_i && b_addr_i == ADDR_W'(ADDR_BELL)) ? b_wlow : '0;

  assert_empty_drop_R5: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    ($past(ab_empty) & ~ab_empty & ~$past(a_tx_wr)) == '0);

  for (genvar i = 0; i < CH_N; i++) begin : g_hold
    assert_word_hold_R4: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
      !$past(ab_empty[i]) |-> $stable(ab_word[i]));
  end

  assert_full_drop_R3: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    ($past(ab_full) & ~ab_full & ~$past(b_rx_rd)) == '0);

  assert_pend_drop_R7: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    ($past(b_pend) & ~b_pend & ~$past(b_clr)) == '0);

  assert_ring_kept_R8: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (|b_hit) |=> ((b_pend & $past(b_hit)) == $past(b_hit)));

  assert_irq_gate_a_R9: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (a_ien == '0) |-> !a_irq_o);

  assert_irq_gate_b_R9: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (b_ien == '0) |-> !b_irq_o);
endmodule

bind ipc_mailbox ipc_mailbox_chk u_chk (
  .clk_a_i(clk_a_i), .clk_b_i(clk_b_i), .rst_ni(rst_ni),
  .a_irq_o(a_irq_o), .b_irq_o(b_irq_o), .a_ien(a_ien), .b_ien(b_ien),
  .ab_empty(ab_empty), .a_tx_wr(a_tx_wr), .ab_word(ab_word),
  .ab_full(ab_full), .b_rx_rd(b_rx_rd), .b_pend(b_pend), .b_hit(b_hit),
  .b_we_i(b_we_i), .b_addr_i(b_addr_i), .b_wlow(b_wdata_i[mbox_pkg::CH_N-1:0]));

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;
  logic clk_a = 0, clk_b = 0, rst_n = 0;
  logic a_we = 0, a_re = 0, b_we = 0, b_re = 0;
  logic [3:0]  a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0, a_rdata, b_rdata;
  logic a_irq, b_irq;
  int checks = 0, errors = 0;
  logic [31:0] q_ab[4][$];
  logic [31:0] q_ba[4][$];

  always #5 clk_a = ~clk_a;
  initial begin #3; forever #7 clk_b = ~clk_b; end

  ipc_mailbox uut (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .a_we_i(a_we), .a_re_i(a_re), .a_addr_i(a_addr), .a_wdata_i(a_wdata),
    .a_rdata_o(a_rdata), .a_irq_o(a_irq),
    .b_we_i(b_we), .b_re_i(b_re), .b_addr_i(b_addr), .b_wdata_i(b_wdata),
    .b_rdata_o(b_rdata), .b_irq_o(b_irq));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input bit s, input logic [3:0] ad, input logic [31:0] d);
    if (!s) begin
      @(negedge clk_a); a_we = 1; a_addr = ad; a_wdata = d;
      @(negedge clk_a); a_we = 0;
    end else begin
      @(negedge clk_b); b_we = 1; b_addr = ad; b_wdata = d;
      @(negedge clk_b); b_we = 0;
    end
  endtask

  task automatic rd(input bit s, input logic [3:0] ad, output logic [31:0] d);
    if (!s) begin
      @(negedge clk_a); a_addr = ad; a_re = 1; #1 d = a_rdata;
      @(negedge clk_a); a_re = 0;
    end else begin
      @(negedge clk_b); b_addr = ad; b_re = 1; #1 d = b_rdata;
      @(negedge clk_b); b_re = 0;
    end
  endtask

  task automatic waitc(input bit s, input int n);
    repeat (n) begin
      if (!s) @(posedge clk_a); else @(posedge clk_b);
    end
  endtask

  // sends a word through the model: accepted only when the slot is empty
  task automatic send(input bit s, input int ch, input logic [31:0] d);
    if (!s) begin if (q_ab[ch].size() == 0) q_ab[ch].push_back(d); end
    else    begin if (q_ba[ch].size() == 0) q_ba[ch].push_back(d); end
    wr(s, 4'(ch), d);
  endtask

  task automatic recv(input bit s, input int ch, input string r);
    logic [31:0] v, e;
    rd(s, 4'(4 + ch), v);
    if (s) e = q_ab[ch].pop_front(); else e = q_ba[ch].pop_front();
    chk(r, v, e);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk_b);
    rst_n = 1;

    // R1 reset state
    rd(0, 8, v); chk("R1 a status", v, 32'h00F);
    rd(1, 8, v); chk("R1 b status", v, 32'h00F);
    rd(1, 9, v); chk("R1 b enable", v, 0);
    chk("R1 irqs", {31'd0, a_irq | b_irq}, 0);

    // R2 A->B on every slot
    for (int i = 0; i < 4; i++) send(0, i, 32'hA5C3_0000 + 32'(i * 17));
    waitc(1, 3);
    rd(1, 8, v); chk("R2 b full bits", v, 32'h0FF);
    rd(0, 8, v); chk("R5 a not empty", v, 32'h000);

    // R4 second write ignored
    send(0, 0, 32'hDEAD_BEEF);
    waitc(0, 20);
    rd(0, 8, v); chk("R5 a still not empty", v, 32'h000);

    recv(1, 0, "R4 R2 b slot0 word");
    rd(1, 8, v); chk("R3 b full0 cleared", v, 32'h0EF);
    for (int i = 1; i < 4; i++) recv(1, i, "R2 b slot word");
    waitc(0, 4);
    rd(0, 8, v); chk("R3 a empty back", v, 32'h00F);

    // R2 B->A with extreme patterns
    send(1, 3, 32'hFFFF_FFFF);
    send(1, 1, 32'h0000_0000);
    waitc(0, 3);
    rd(0, 8, v); chk("R2 a full bits", v, 32'h0AF);
    rd(1, 8, v); chk("R5 b empties", v, 32'h005);
    recv(0, 3, "R2 a slot3 word");
    recv(0, 1, "R2 a slot1 word");
    waitc(1, 4);
    rd(1, 8, v); chk("R3 b empty back", v, 32'h00F);

    // R6 R7 doorbells A->B
    wr(0, 10, 32'h5);
    waitc(1, 4);
    rd(1, 11, v); chk("R6 b pending", v, 32'h5);
    rd(1, 8, v);  chk("R6 b status pend", v, 32'h50F);
    wr(1, 11, 32'h1);
    rd(1, 11, v); chk("R7 clear bit0", v, 32'h4);
    wr(1, 11, 32'h0);
    rd(1, 11, v); chk("R7 zero write keeps", v, 32'h4);
    wr(1, 11, 32'h4);
    rd(1, 11, v); chk("R7 cleared all", v, 32'h0);

    // R8 ring arrives on the same B edge as a clear of that bit
    @(negedge clk_a); a_we = 1; a_addr = 10; a_wdata = 32'h2;
    @(posedge clk_a); #1 a_we = 0;
    @(posedge clk_b); @(posedge clk_b);
    @(negedge clk_b); b_we = 1; b_addr = 11; b_wdata = 32'h2;
    @(posedge clk_b); #1 b_we = 0;
    rd(1, 11, v); chk("R8 ring survives clear", v, 32'h2);
    wr(1, 11, 32'h2);

    // R9 interrupt gating and acknowledge
    wr(1, 9, 32'h040);
    #1 chk("R9 b irq idle", {31'd0, b_irq}, 0);
    send(0, 2, 32'h1234_5678);
    waitc(1, 3); #1;
    chk("R9 b irq rx full", {31'd0, b_irq}, 1);
    wr(0, 9, 32'h004);
    #1 chk("R9 a irq waiting ack", {31'd0, a_irq}, 0);
    recv(1, 2, "R2 b slot2 word");
    #1 chk("R9 b irq after read", {31'd0, b_irq}, 0);
    waitc(0, 4); #1;
    chk("R9 a irq ack", {31'd0, a_irq}, 1);
    wr(0, 9, 32'h0);
    wr(1, 10, 32'h8);
    waitc(0, 4); #1;
    chk("R9 a masked bell", {31'd0, a_irq}, 0);
    wr(0, 9, 32'h800);
    #1 chk("R9 a bell irq", {31'd0, a_irq}, 1);
    wr(0, 11, 32'h8);
    #1 chk("R9 a bell cleared", {31'd0, a_irq}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule